// File: doc/BRIEF.md
# Peripheral Clock Gating Bank

This block holds one clock-enable bit per peripheral and produces a gated copy of the source clock for each peripheral. Software reaches it over a simple synchronous register bus. It turns enables on by writing ones to a set register. It turns them off by writing ones to a clear register. It reads the live state back from a status register. Bits written as zero never disturb other peripherals, so independent drivers can share the bank without a read-modify-write sequence.

The enables are grouped into 32-bit banks, and the peripheral ID picks the bank and the bit. The lowest IDs are permanently on, because they feed logic that must never lose its clock. Each gated clock is produced by a cell that captures its enable on the falling edge of the source clock before the AND, so an output never shows a shortened pulse.

Top module: `pclk_gate_bank`

## Requirements
- R1: After reset, `clk_en_o` reads 1 for IDs 0 and 1 and 0 for every other ID.
- R2: A write to the bank 0 set register (byte address 0x00) sets the enable of ID n for every bit n of the write data that is 1. Enables for data bits that are 0 keep their value.
- R3: A write to the bank 0 clear register (0x04) clears the enable of ID n for every bit n of the write data that is 1. Enables for data bits that are 0 keep their value.
- R4: A read of a status register returns the enable state of its bank, with bit n of bank b giving ID 32*b+n. Bank 0 status is at 0x08 and bank 1 status is at 0x18. `rdata_o` is loaded on the rising edge that samples `re_i` and holds until the next read.
- R5: IDs 0 and 1 always read as enabled, and a set or clear write touching bits 0 or 1 of bank 0 leaves them enabled.
- R6: IDs 32 to 63 use bank 1: the set register is at 0x10 and the clear register is at 0x14, and ID 32+n is at bit n.
- R7: While an ID is enabled, its `gclk_o` bit copies the source clock's high phase. While an ID is disabled, its bit stays low. A change takes effect at the falling edge after the enable updates.
- R8: A write to a status register, to 0x0C or 0x1C, to a misaligned address, or to an address with bits above bit 4 set, changes no enable. A read of any address other than a status register returns 0.
- R9: `clk_en_o` takes its new value on the rising edge that samples `we_i`, with no extra cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock and bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 32 | Registered read data |
| clk_en_o | output | NUM_IDS | Current enable per peripheral ID |
| gclk_o | output | NUM_IDS | Gated clock per peripheral ID |

## Verification
The enable state lives only in the bank registers, so a corrupted bit shows up on `clk_en_o` at the same rising edge as the write that caused it. It reaches the status read one access later. On `gclk_o` it appears half a cycle after that. A fault that leaks into a neighbouring bit or into the other bank is caught by comparing the whole 64-bit enable vector after every access. A gate cell that latches on the wrong edge shows up as a gated clock that is high during the low phase, or that misses the first high phase after an enable.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int BANK_BITS = 32;

  // word index inside a 16-byte bank window
  typedef enum logic [1:0] {
    REG_SET  = 2'd0,
    REG_CLR  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } pcg_reg_e;
endpackage

// File: rtl/pcg_decode.sv
module pcg_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2,
  localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output pcg_pkg::pcg_reg_e  kind_o,
  output logic [BSEL_W-1:0]  bank_o,
  output logic               hit_o
);
  localparam int TOP_LSB = 4 + BSEL_W;

  logic upper_zero;
  logic aligned;
  logic bank_ok;

  generate
    if (ADDR_W > TOP_LSB) begin : g_upper
      assign upper_zero = (addr_i[ADDR_W-1:TOP_LSB] == '0);
    end else begin : g_no_upper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign aligned = (addr_i[1:0] == 2'b00);
  assign bank_o  = addr_i[4 +: BSEL_W];
  assign bank_ok = (int'(bank_o) < NUM_BANKS);

  always_comb begin
    kind_o = pcg_pkg::pcg_reg_e'(addr_i[3:2]);
    hit_o  = aligned && upper_zero && bank_ok && (kind_o != pcg_pkg::REG_NONE);
    if (!hit_o) kind_o = pcg_pkg::REG_NONE;
  end
endmodule

// File: rtl/pcg_bank.sv
module pcg_bank #(
  parameter logic [pcg_pkg::BANK_BITS-1:0] FIXED_MASK = '0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          set_i,
  input  logic                          clr_i,
  input  logic [pcg_pkg::BANK_BITS-1:0] wdata_i,
  output logic [pcg_pkg::BANK_BITS-1:0] en_o
);
  localparam int W = pcg_pkg::BANK_BITS;

  logic [W-1:0] en_q;
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;
  logic [W-1:0] en_d;

  assign set_bits = set_i ? wdata_i : '0;
  assign clr_bits = clr_i ? wdata_i : '0;
  // clear dominates; fixed bits are forced on
  assign en_d = ((en_q | set_bits) & ~clr_bits) | FIXED_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= FIXED_MASK;
    else if (set_i || clr_i) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/pcg_gate_cell.sv
module pcg_gate_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lo_q;

  // capture while clock is low so the AND never cuts a high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_lo_q <= RST_VAL;
    else         en_lo_q <= en_i;
  end

  assign gclk_o = clk_i & en_lo_q;
endmodule

// File: rtl/pclk_gate_bank.sv
module pclk_gate_bank #(
  parameter int NUM_IDS   = 64,
  parameter int NUM_FIXED = 2,
  parameter int ADDR_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_IDS-1:0] clk_en_o,
  output logic [NUM_IDS-1:0] gclk_o
);
  localparam int W         = pcg_pkg::BANK_BITS;
  localparam int NUM_BANKS = (NUM_IDS + W - 1) / W;
  localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [W-1:0] FIXED0 = W'((64'd1 << NUM_FIXED) - 64'd1);

  pcg_pkg::pcg_reg_e   kind;
  logic [BSEL_W-1:0]   bank_sel;
  logic                hit;
  logic [W-1:0]        bank_en [NUM_BANKS];
  logic [NUM_BANKS*W-1:0] en_flat;
  logic [31:0]         rdata_q;

  pcg_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS)
  ) u_decode (
    .addr_i(addr_i),
    .kind_o(kind),
    .bank_o(bank_sel),
    .hit_o (hit)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [W-1:0] FM = (b == 0) ? FIXED0 : '0;
      logic sel;
      assign sel = we_i && hit && (int'(bank_sel) == b);
      pcg_bank #(.FIXED_MASK(FM)) u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (sel && (kind == pcg_pkg::REG_SET)),
        .clr_i  (sel && (kind == pcg_pkg::REG_CLR)),
        .wdata_i(wdata_i),
        .en_o   (bank_en[b])
      );
      assign en_flat[b*W +: W] = bank_en[b];
    end

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_gate
      pcg_gate_cell #(.RST_VAL(i < NUM_FIXED)) u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_flat[i]),
        .gclk_o(gclk_o[i])
      );
    end
  endgenerate

  assign clk_en_o = en_flat[NUM_IDS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (re_i) rdata_q <= (hit && kind == pcg_pkg::REG_STAT) ? bank_en[bank_sel] : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pclk_gate_bank_chk.sv
module pclk_gate_bank_chk #(
  parameter int NUM_IDS = 64,
  parameter int ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic               we_i,
  input logic               re_i,
  input logic [31:0]        rdata_o,
  input logic [NUM_IDS-1:0] clk_en_o
);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_ST0  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'(8'h10);

  AST_SET_BANK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SET0) |=> ((clk_en_o[31:0] & $past(wdata_i)) == $past(wdata_i))); // R2

  AST_CLR_BANK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CLR0) |=> ((clk_en_o[31:0] & $past(wdata_i) & ~32'h3) == 32'h0)); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(clk_en_o)); // R8

  AST_STATUS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == A_ST0) |=> (rdata_o == $past(clk_en_o[31:0]))); // R4

  generate
    if (NUM_IDS >= 64) begin : g_b1
      AST_SET_BANK1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == A_SET1) |=> ((clk_en_o[63:32] & $past(wdata_i)) == $past(wdata_i))); // R6
    end
  endgenerate
endmodule

bind pclk_gate_bank pclk_gate_bank_chk #(
  .NUM_IDS(NUM_IDS),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .clk_en_o(clk_en_o)
);

// File: tb/pclk_gate_bank_tb.sv
module pclk_gate_bank_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;
  logic [63:0] clk_en_o;
  logic [63:0] gclk_o;

  int checks = 0;
  int failures = 0;
  logic [63:0] m;

  always #10 clk_i = ~clk_i;

  pclk_gate_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .clk_en_o(clk_en_o), .gclk_o(gclk_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic mapped(input logic [7:0] a);
    return (a[7:5] == 3'b000) && (a[1:0] == 2'b00) && (a[3:2] != 2'b11);
  endfunction

  function automatic logic [63:0] model_write(input logic [63:0] cur, input logic [7:0] a,
                                              input logic [31:0] d);
    logic [63:0] mask;
    logic [63:0] nxt;
    nxt  = cur;
    mask = a[4] ? {d, 32'h0} : {32'h0, d};
    if (mapped(a) && a[3:2] == 2'b00) nxt = cur | mask;
    if (mapped(a) && a[3:2] == 2'b01) nxt = cur & ~mask;
    return nxt | 64'h3;
  endfunction

  function automatic logic [31:0] model_read(input logic [63:0] cur, input logic [7:0] a);
    if (mapped(a) && a[3:2] == 2'b10) return a[4] ? cur[63:32] : cur[31:0];
    return 32'h0;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [63:0] nxt;
    nxt = model_write(m, a, d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    check("R9 before edge", clk_en_o, m);
    @(posedge clk_i); #1;
    m = nxt;
    check("R2/R3/R5/R6/R8 enables", clk_en_o, m);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    @(posedge clk_i); #1;
    check(req, {32'h0, rdata_o}, {32'h0, model_read(m, a)});
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic check_gclk();
    @(posedge clk_i); #5;
    check("R7 high phase", gclk_o, m);
    @(negedge clk_i); #5;
    check("R7 low phase", gclk_o, 64'h0);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m = 64'h3;
    repeat (3) @(negedge clk_i);
    check("R1 reset enables", clk_en_o, 64'h3);
    rst_ni = 1'b1;
    check_gclk();
    rd(8'h08, "R4/R1 status bank0");
    rd(8'h18, "R4/R1 status bank1");

    wr(8'h00, 32'hFFFF_FFFF);          // R2
    check_gclk();
    wr(8'h04, 32'h0000_00F3);          // R3 R5
    rd(8'h08, "R3/R5 status after clear");
    wr(8'h10, 32'h8000_0001);          // R6
    rd(8'h18, "R6 status bank1");
    check_gclk();
    wr(8'h14, 32'h8000_0000);          // R6 clear
    wr(8'h04, 32'hFFFF_FFFF);          // R5
    check("R5 fixed ids", clk_en_o[1:0], 64'h3);
    wr(8'h08, 32'hFFFF_FFFF);          // R8 status write
    wr(8'h0C, 32'hFFFF_FFFF);          // R8
    wr(8'h1C, 32'hFFFF_FFFF);          // R8
    wr(8'h01, 32'hFFFF_FFFF);          // R8 misaligned
    wr(8'h20, 32'hFFFF_FFFF);          // R8 upper bits
    rd(8'h00, "R8 read non-status");
    rd(8'h14, "R8 read non-status");
    check_gclk();

    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [7:0] a;
      sel = int'($urandom % 9);
      case (sel)
        0: a = 8'h00;
        1: a = 8'h04;
        2: a = 8'h08;
        3: a = 8'h10;
        4: a = 8'h14;
        5: a = 8'h18;
        6: a = 8'h0C;
        default: a = 8'($urandom);
      endcase
      if ($urandom % 3 == 0) rd(a, "R4/R8 random read");
      else wr(a, $urandom);
      if (i % 50 == 0) check_gclk();
    end
    rd(8'h08, "R4 final bank0");
    rd(8'h18, "R4 final bank1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule